// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Interrupt Sensing

This block gives software control over a bank of general-purpose pins through a word-wide register bus. Software chooses which pins drive, sets or clears individual output bits without a read-modify-write, and reads the pin levels after they have been brought into the clock domain. A build parameter decides whether a 1 in the direction register means "drive" or "listen".

Each pin also feeds an interrupt lane. A lane can sense an edge (sticky until software acknowledges it) or a level (live while the level holds), with a per-pin bit picking the active direction. Two independent gates, an enable and a mask, must both be open for a pin to reach the single combined interrupt line. Sensing both edges of a pin is left to software: after each event it writes the polarity bit to the opposite of the pin's present level.

Top module: `pio_bank`

## Requirements
- R1: After reset the direction, output, enable, type, polarity and mask registers read zero (direction reads all ones in the inverted variant), `pin_oe` is all zero and `irq_out` is low.
- R2: Byte offsets decode as direction 0x00, input 0x04, set 0x0C, clear 0x10, enable 0x14, type 0x18, polarity 0x1C, pending 0x20, mask 0x24; read data and `bus_rvalid` appear one clock after `bus_rd`, and any other offset reads zero.
- R3: Writing 1s to offset 0x0C sets those output bits, writing 1s to 0x10 clears them, 0 bits leave the output unchanged, and reads of either offset return the current output value.
- R4: With `OE_INV`=0 `pin_oe` bit i equals direction bit i; with `OE_INV`=1 it is the inverse.
- R5: Write bits at or above `NPINS` are ignored and read as zero; `NPINS` must be below 32.
- R6: The input register returns the pin levels through a two-flop synchroniser: a pin change made before clock edge 1 is first visible to a read sampled at edge 3.
- R7: With type bit 0 (edge), polarity 1 captures a rising and 0 a falling edge into a sticky pending bit; writing 1 to that pending bit clears it and writing 0 has no effect.
- R8: With type bit 1 (level), the pending bit is 1 exactly while the synchronised pin equals its polarity bit, and a write of 1 to pending does not clear it.
- R9: `irq_out` is a registered OR over pins of pending AND enable AND mask; a pending pin with either gate at 0 keeps it low.
- R10: Changing a polarity bit while the pin is steady produces no pending event, so rewriting polarity to the inverse of the pin after each event senses both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High one clock after a read strobe |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch toward the pads |
| pin_oe | output | NPINS | Active-high pad drive enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume pins are quiet while reset is applied and that read and write strobes never share a cycle with a different offset meaning; the bench drives every bus access for exactly one clock and changes pins only between edges. Pin changes are spaced several clocks apart so each edge passes the synchroniser before the next one, and pending bits are flushed before each interrupt scenario so that earlier pin activity never leaks into expected values.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR   = 6'h00,
        OFS_LEVEL = 6'h04,
        OFS_SET   = 6'h0C,
        OFS_CLR   = 6'h10,
        OFS_IEN   = 6'h14,
        OFS_ITYPE = 6'h18,
        OFS_IPOL  = 6'h1C,
        OFS_IPEND = 6'h20,
        OFS_IMASK = 6'h24
    } pio_ofs_e;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        logic dir;
        logic level;
        logic set;
        logic clr;
        logic ien;
        logic itype;
        logic ipol;
        logic ipend;
        logic imask;
        logic hit;
    } pio_dec_t;

    function automatic pio_dec_t pio_decode(input logic [ADDR_W-1:0] a);
        pio_dec_t d;
        d = '0;
        case (a)
            OFS_DIR:   d.dir   = 1'b1;
            OFS_LEVEL: d.level = 1'b1;
            OFS_SET:   d.set   = 1'b1;
            OFS_CLR:   d.clr   = 1'b1;
            OFS_IEN:   d.ien   = 1'b1;
            OFS_ITYPE: d.itype = 1'b1;
            OFS_IPOL:  d.ipol  = 1'b1;
            OFS_IPEND: d.ipend = 1'b1;
            OFS_IMASK: d.imask = 1'b1;
            default:   d       = '0;
        endcase
        d.hit = d.dir | d.level | d.set | d.clr | d.ien |
                d.itype | d.ipol | d.ipend | d.imask;
        return d;
    endfunction

endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
module pio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/pio_irq_lane.sv
`timescale 1ns/1ps
module pio_irq_lane
    import pio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_in,
    input  sense_e sense,
    input  logic   pol,
    input  logic   clr_req,
    output logic   pending
);
    logic prev_q;
    logic edge_q;
    logic edge_hit;

    assign edge_hit = pol ? (sync_in & ~prev_q) : (~sync_in & prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
            if (sense == SENSE_LEVEL)
                edge_q <= 1'b0;
            else if (edge_hit)
                edge_q <= 1'b1;
            else if (clr_req)
                edge_q <= 1'b0;
        end
    end

    assign pending = (sense == SENSE_LEVEL) ? (sync_in == pol) : edge_q;

    // R7: a captured edge only drops on acknowledge or a switch to level mode
    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(edge_q) |-> $past(clr_req || sense == SENSE_LEVEL));

    // R10: a captured edge needs an actual input transition
    p_edge_needs_change_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_q) |-> $past(sync_in != prev_q));
endmodule

// File: rtl/pio_bank.sv
`timescale 1ns/1ps
module pio_bank
    import pio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter bit OE_INV = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);
    localparam int PAD = REG_W - NPINS;
    localparam logic [NPINS-1:0] DIR_RST = OE_INV ? {NPINS{1'b1}} : {NPINS{1'b0}};

    if (NPINS < 1 || NPINS >= REG_W) begin : g_bad_width
        $error("pio_bank: NPINS must lie in 1..31");
    end

    pio_dec_t         dec;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] dir_q, out_q, ien_q, itype_q, ipol_q, imask_q;
    logic [NPINS-1:0] in_q;
    logic [NPINS-1:0] pend_v;
    logic [NPINS-1:0] pend_clr;
    logic [NPINS-1:0] rd_sel;
    logic             irq_q;
    logic             unused_wr_hi;

    assign dec          = pio_decode(bus_addr);
    assign wbits        = bus_wdata[NPINS-1:0];
    assign unused_wr_hi = ^bus_wdata[REG_W-1:NPINS];

    pio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_RST;
            out_q   <= '0;
            ien_q   <= '0;
            itype_q <= '0;
            ipol_q  <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            if (dec.dir)   dir_q   <= wbits;
            if (dec.set)   out_q   <= out_q | wbits;
            if (dec.clr)   out_q   <= out_q & ~wbits;
            if (dec.ien)   ien_q   <= wbits;
            if (dec.itype) itype_q <= wbits;
            if (dec.ipol)  ipol_q  <= wbits;
            if (dec.imask) imask_q <= wbits;
        end
    end

    assign pend_clr = (bus_wr && dec.ipend) ? wbits : '0;

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        pio_irq_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .sync_in (in_q[i]),
            .sense   (sense_e'(itype_q[i])),
            .pol     (ipol_q[i]),
            .clr_req (pend_clr[i]),
            .pending (pend_v[i])
        );
    end

    always_comb begin
        rd_sel = '0;
        if (dec.dir)           rd_sel = dir_q;
        if (dec.level)         rd_sel = in_q;
        if (dec.set | dec.clr) rd_sel = out_q;
        if (dec.ien)           rd_sel = ien_q;
        if (dec.itype)         rd_sel = itype_q;
        if (dec.ipol)          rd_sel = ipol_q;
        if (dec.ipend)         rd_sel = pend_v;
        if (dec.imask)         rd_sel = imask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd)
                bus_rdata <= {{PAD{1'b0}}, rd_sel};
            irq_q <= |(pend_v & ien_q & imask_q);
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = OE_INV ? ~dir_q : dir_q;
    assign irq_out = irq_q;

    // R1: pads stay undriven right after reset
    p_oe_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pin_oe == '0);

    // R2: every read strobe is answered on the next clock
    p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    // R2: unmapped offsets read zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !dec.hit) |=> bus_rdata == '0);

    // R3: set writes raise the written bits
    p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.set) |=> (pin_out & $past(wbits)) == $past(wbits));

    // R3: clear writes lower the written bits
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.clr) |=> (pin_out & $past(wbits)) == '0);

    // R3: the output latch moves only on set or clear writes
    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (dec.set || dec.clr)) |=> $stable(pin_out));

    // R9: no open gate, no interrupt
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        ((ien_q & imask_q) == '0) |=> !irq_out);
endmodule

// File: tb/pio_bank_tb.sv
`timescale 1ns/1ps
module pio_bank_tb;
    import pio_pkg::*;

    localparam int NP = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [REG_W-1:0]  bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [REG_W-1:0]  bus_rdata;
    logic              bus_rvalid;
    logic [NP-1:0]     pins = '0;
    logic [NP-1:0]     pin_out, pin_oe;
    logic              irq_out;

    logic [REG_W-1:0]  inv_rdata;
    logic              inv_rvalid;
    logic [NP-1:0]     inv_out, inv_oe;
    logic              inv_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [REG_W-1:0] exp_q[$];
    string            tag_q[$];

    always #5 clk = ~clk;

    pio_bank #(.NPINS(NP), .OE_INV(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pins), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out)
    );

    pio_bank #(.NPINS(NP), .OE_INV(1'b1)) u_dut_inv (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(inv_rdata),
        .bus_rvalid(inv_rvalid), .pin_in(pins), .pin_out(inv_out),
        .pin_oe(inv_oe), .irq_out(inv_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: push the expected read data, then issue the strobe
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compare each returned word against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 32'hxxxx_xxxx, "R2 unexpected read data");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata, e, t);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk(pin_oe, '0, "R1 pin_oe after reset");
        chk(inv_oe, '0, "R1 inverted pin_oe after reset");
        chk(irq_out, 1'b0, "R1 irq_out after reset");
        rd(OFS_DIR,   '0, "R1 direction reset");
        rd(OFS_SET,   '0, "R1 output reset");
        rd(OFS_IEN,   '0, "R1 enable reset");
        rd(OFS_ITYPE, '0, "R1 type reset");
        rd(OFS_IPOL,  '0, "R1 polarity reset");
        rd(OFS_IMASK, '0, "R1 mask reset");
        rd(OFS_IPEND, '0, "R1 pending reset");

        // R4 / R5 direction and polarity variant
        wr(OFS_DIR, 32'hFFFF_00A5);
        rd(OFS_DIR, 32'h0000_00A5, "R5 upper direction bits dropped");
        chk(pin_oe, 16'h00A5, "R4 pin_oe plain");
        chk(inv_oe, 16'hFF5A, "R4 pin_oe inverted");

        // R3 set / clear
        wr(OFS_SET, 32'h0000_0F0F);
        chk(pin_out, 16'h0F0F, "R3 set bits");
        rd(OFS_SET, 32'h0000_0F0F, "R3 read at set offset");
        wr(OFS_CLR, 32'h0000_0003);
        chk(pin_out, 16'h0F0C, "R3 clear bits");
        rd(OFS_CLR, 32'h0000_0F0C, "R3 read at clear offset");
        wr(OFS_SET, 32'h0);
        wr(OFS_CLR, 32'h0);
        chk(pin_out, 16'h0F0C, "R3 zero writes leave output");
        wr(OFS_SET, 32'hFFFF_0000);
        chk(pin_out, 16'h0F0C, "R5 set above pin count ignored");

        // R2 unmapped offsets
        rd(6'h08, '0, "R2 hole at 0x08");
        rd(6'h28, '0, "R2 offset 0x28");
        rd(6'h3C, '0, "R2 offset 0x3C");

        // R6 synchroniser latency
        pins = 16'h1234;
        rd(OFS_LEVEL, 32'h0, "R6 not visible at edge 1");
        rd(OFS_LEVEL, 32'h0, "R6 not visible at edge 2");
        rd(OFS_LEVEL, 32'h0000_1234, "R6 visible at edge 3");
        pins = '0;
        tick(5);

        // R7 / R9 rising edge on pin 0
        wr(OFS_IPEND, 32'hFFFF);
        wr(OFS_IPOL,  32'h0001);
        wr(OFS_ITYPE, 32'h0000);
        wr(OFS_IEN,   32'h0001);
        wr(OFS_IMASK, 32'h0001);
        tick(2);
        chk(irq_out, 1'b0, "R9 no event yet");
        pins[0] = 1'b1;
        tick(6);
        chk(irq_out, 1'b1, "R9 irq on enabled rising edge");
        rd(OFS_IPEND, 32'h1, "R7 rising edge captured");
        pins[0] = 1'b0;
        tick(6);
        rd(OFS_IPEND, 32'h1, "R7 pending sticky after fall");
        wr(OFS_IPEND, 32'h0);
        rd(OFS_IPEND, 32'h1, "R7 write 0 keeps pending");
        wr(OFS_IPEND, 32'h1);
        tick(3);
        rd(OFS_IPEND, 32'h0, "R7 write 1 clears pending");
        chk(irq_out, 1'b0, "R9 irq drops after acknowledge");

        // R7 / R9 falling edge on pin 1 with gating
        pins[1] = 1'b1;
        tick(6);
        rd(OFS_IPEND, 32'h0, "R7 rising ignored with polarity 0");
        pins[1] = 1'b0;
        tick(6);
        rd(OFS_IPEND, 32'h2, "R7 falling edge captured");
        chk(irq_out, 1'b0, "R9 pending but not enabled");
        wr(OFS_IEN, 32'h0003);
        tick(3);
        chk(irq_out, 1'b0, "R9 enabled but masked");
        wr(OFS_IMASK, 32'h0003);
        tick(3);
        chk(irq_out, 1'b1, "R9 enabled and unmasked");
        wr(OFS_IPEND, 32'h2);
        tick(3);
        chk(irq_out, 1'b0, "R9 cleared");

        // R8 level sensing on pin 2
        wr(OFS_IPOL,  32'h0005);
        wr(OFS_ITYPE, 32'h0004);
        tick(3);
        rd(OFS_IPEND, 32'h0, "R8 low pin, high polarity");
        pins[2] = 1'b1;
        tick(4);
        rd(OFS_IPEND, 32'h4, "R8 level active");
        pins[2] = 1'b0;
        tick(4);
        rd(OFS_IPEND, 32'h0, "R8 level released");
        wr(OFS_IPOL, 32'h0001);
        tick(2);
        rd(OFS_IPEND, 32'h4, "R8 active-low level");
        wr(OFS_IPEND, 32'h4);
        rd(OFS_IPEND, 32'h4, "R8 acknowledge does not clear level");
        wr(OFS_ITYPE, 32'h0000);
        tick(2);
        rd(OFS_IPEND, 32'h0, "R8 back to edge mode, nothing pending");

        // R10 both edges on pin 3 by polarity flipping
        wr(OFS_IPOL, 32'h0009);
        tick(2);
        pins[3] = 1'b1;
        tick(6);
        rd(OFS_IPEND, 32'h8, "R10 first edge");
        wr(OFS_IPEND, 32'h8);
        wr(OFS_IPOL, 32'h0001);
        tick(3);
        rd(OFS_IPEND, 32'h0, "R10 polarity flip alone raises nothing");
        pins[3] = 1'b0;
        tick(6);
        rd(OFS_IPEND, 32'h8, "R10 opposite edge");

        tick(3);
        chk(exp_q.size(), 0, "R2 all reads answered");
        finish_run();
    end
endmodule